// File: doc/BRIEF.md
# DRAM Refresh and Wake-up Scheduler

This block keeps a 1024-row dynamic memory alive and brings it out of power-up. After reset it stays silent for a programmable pause. It then asks for a fixed number of wake-up refresh cycles, and only after the last of these completes does it declare the memory ready. From then on an interval timer adds one owed refresh to a small backlog every interval. The default interval of 780 cycles at 50 MHz spreads 1024 refreshes over the 16 ms retention window.

Every refresh is a CAS-before-RAS cycle, so no row address is needed: the memory's own counter picks the row. The scheduler raises a request while refreshes are owed and its strobe engine is idle. It starts a cycle when the access sequencer grants the bus, or at once when the bus-ownership input says no access sequencer is competing. During that cycle it drives both column strobes and the row strobe itself.

If the backlog is already full when another interval expires, the retention guarantee is lost. The block then sets a sticky error flag, withdraws ready and runs the whole wake-up burst again.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied and on the first clock after it, ref_req, mem_ready and ovf_err are 0, and ras_n and both cas_n bits are 1.
- R2: For the first PAUSE_CYC clocks after reset, ref_req and mem_ready stay 0.
- R3: After the pause exactly WAKE_CNT refresh cycles are performed. mem_ready rises on the clock that ends the last of them.
- R4: Once mem_ready is high, every REF_INTERVAL clocks add one owed refresh. ref_req is high whenever refreshes are owed and no refresh cycle is in progress.
- R5: A refresh cycle starts only on a clock where ref_req is high and ref_gnt or bus_own is high. ref_req is 0 while a cycle is in progress.
- R6: In each refresh cycle both cas_n bits go low T_CSR clocks before ras_n goes low.
- R7: ras_n stays low for T_RAS clocks. Both cas_n bits rise T_CHR clocks after ras_n falls, while ras_n is still low.
- R8: After ras_n rises, both strobes stay high for T_RP clocks before the next cycle can lower cas_n.
- R9: If an interval expires on the same clock that a refresh cycle completes, the number of owed refreshes does not change, and no overflow occurs even at the MAX_PEND limit.
- R10: If an interval expires while MAX_PEND refreshes are owed and no cycle completes on that clock, ovf_err is set and mem_ready falls. WAKE_CNT fresh wake-up cycles are then owed.
- R11: ovf_err stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Access sequencer grants the bus for a refresh |
| bus_own | input | 1 | Scheduler already owns the bus; no grant needed |
| ref_req | output | 1 | A refresh is owed and the strobe engine is idle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes for the upper and lower byte, active low, driven together |
| mem_ready | output | 1 | Wake-up complete; memory usable |
| ovf_err | output | 1 | Sticky backlog overflow flag |

## Verification
The interval timer and the strobe engine update the owed-refresh count on their own, so an interval tick and the end of a refresh cycle can land on the same clock. That collision matters most when the backlog sits at its limit. The bench provokes it by withholding the grant for a delay that is swept one clock at a time, so that the end of a released cycle passes across the tick phase. A behavioural model tracks the owed count, and every clock the bench compares ref_req, the strobes and the error flag with it. A lost or doubled count shows up as an extra or missing request, or as a false overflow.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } dref_phase_e;
endpackage

// File: rtl/dref_cbr_engine.sv
module dref_cbr_engine #(
  parameter int T_CSR = 1,
  parameter int T_CHR = 1,
  parameter int T_RAS = 3,
  parameter int T_RP  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic cyc_done,
  output logic ras_n,
  output logic cas_n
);
  localparam int TOTAL   = T_CSR + T_RAS + T_RP;
  localparam int SW      = $clog2(TOTAL);
  localparam int CAS_END = T_CSR + T_CHR;
  localparam int RAS_END = T_CSR + T_RAS;
  localparam logic [SW-1:0] STEP_LAST = SW'(TOTAL - 1);

  logic [SW-1:0] step, step_n;
  logic          busy_n;

  assign cyc_done = busy && (step == STEP_LAST);

  always_comb begin
    busy_n = busy;
    step_n = step;
    if (cyc_done) begin
      busy_n = 1'b0;
      step_n = '0;
    end else if (busy) begin
      step_n = step + 1'b1;
    end else if (start) begin
      busy_n = 1'b1;
      step_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      step  <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      busy  <= busy_n;
      step  <= step_n;
      cas_n <= !(busy_n && (int'(step_n) < CAS_END));
      ras_n <= !(busy_n && (int'(step_n) >= T_CSR) && (int'(step_n) < RAS_END));
    end
  end
endmodule

// File: rtl/dref_phase_ctl.sv
module dref_phase_ctl
  import dref_pkg::*;
#(
  parameter int PAUSE_CYC    = 5000000,
  parameter int REF_INTERVAL = 780,
  parameter int WAKE_CNT     = 8,
  parameter int MAX_PEND     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic cyc_done,
  output logic ref_req,
  output logic mem_ready,
  output logic ovf_err
);
  localparam int TMR_TOP = (PAUSE_CYC > REF_INTERVAL) ? PAUSE_CYC : REF_INTERVAL;
  localparam int TW      = (TMR_TOP > 2) ? $clog2(TMR_TOP) : 1;
  localparam int PEND_TOP = (WAKE_CNT > MAX_PEND) ? WAKE_CNT : MAX_PEND;
  localparam int PW      = $clog2(PEND_TOP + 1);
  localparam logic [TW-1:0] PAUSE_LAST = TW'(PAUSE_CYC - 1);
  localparam logic [TW-1:0] INT_LAST   = TW'(REF_INTERVAL - 1);
  localparam logic [PW-1:0] WAKE_LD    = PW'(WAKE_CNT);
  localparam logic [PW-1:0] PEND_LIM   = PW'(MAX_PEND);
  localparam logic [PW-1:0] PEND_ONE   = PW'(1);

  dref_phase_e   phase;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pend;
  logic          tick;

  assign tick      = (phase == PH_RUN) && (tmr == INT_LAST);
  assign ref_req   = (phase != PH_PAUSE) && (pend != '0) && !busy;
  assign mem_ready = (phase == PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_PAUSE;
      tmr     <= '0;
      pend    <= '0;
      ovf_err <= 1'b0;
    end else begin
      case (phase)
        PH_PAUSE: begin
          if (tmr == PAUSE_LAST) begin
            phase <= PH_WAKE;
            pend  <= WAKE_LD;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        PH_WAKE: begin
          if (cyc_done) begin
            pend <= pend - 1'b1;
            if (pend == PEND_ONE) begin
              phase <= PH_RUN;
              tmr   <= '0;
            end
          end
        end
        PH_RUN: begin
          tmr <= tick ? '0 : tmr + 1'b1;
          if (tick && !cyc_done && (pend == PEND_LIM)) begin
            ovf_err <= 1'b1;
            phase   <= PH_WAKE;
            pend    <= WAKE_LD;
          end else if (tick && !cyc_done) begin
            pend <= pend + 1'b1;
          end else if (!tick && cyc_done) begin
            pend <= pend - 1'b1;
          end
        end
        default: phase <= PH_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PAUSE_CYC    = 5000000,
  parameter int REF_INTERVAL = 780,
  parameter int WAKE_CNT     = 8,
  parameter int MAX_PEND     = 4,
  parameter int T_CSR        = 1,
  parameter int T_CHR        = 1,
  parameter int T_RAS        = 3,
  parameter int T_RP         = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_gnt,
  input  logic       bus_own,
  output logic       ref_req,
  output logic       ras_n,
  output logic [1:0] cas_n,
  output logic       mem_ready,
  output logic       ovf_err
);
  logic busy, cyc_done, cas_one, start;

  assign start = ref_req && (ref_gnt || bus_own);
  assign cas_n = {2{cas_one}};

  dref_phase_ctl #(
    .PAUSE_CYC(PAUSE_CYC), .REF_INTERVAL(REF_INTERVAL),
    .WAKE_CNT(WAKE_CNT), .MAX_PEND(MAX_PEND)
  ) u_phase (
    .clk(clk), .rst(rst), .busy(busy), .cyc_done(cyc_done),
    .ref_req(ref_req), .mem_ready(mem_ready), .ovf_err(ovf_err)
  );

  dref_cbr_engine #(
    .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_cbr (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .cyc_done(cyc_done), .ras_n(ras_n), .cas_n(cas_one)
  );
endmodule

// File: rtl/dref_sched_chk.sv
module dref_sched_chk #(
  parameter int PAUSE_CYC = 5000000
) (
  input logic       clk,
  input logic       rst,
  input logic       ref_req,
  input logic       ras_n,
  input logic [1:0] cas_n,
  input logic       mem_ready,
  input logic       ovf_err
);
  localparam int CW = $clog2(PAUSE_CYC + 1);
  localparam logic [CW-1:0] CNT_LIM = CW'(PAUSE_CYC);
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst < CNT_LIM) since_rst <= since_rst + 1'b1;
  end

  AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CNT_LIM) |-> (!ref_req && !mem_ready)); // R2
  AST_READY_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ready) |-> (ras_n && cas_n == 2'b11)); // R3
  AST_NO_REQ_DURING_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (cas_n != 2'b11 || !ras_n) |-> !ref_req); // R5
  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (cas_n == 2'b00 && $past(cas_n) == 2'b00)); // R6
  AST_CAS_RISES_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_n[0]) |-> !ras_n); // R7
  AST_CAS_PAIR: assert property (@(posedge clk) disable iff (rst)
    cas_n[0] == cas_n[1]); // R6
  AST_ERR_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_err) |-> !mem_ready); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err); // R11
endmodule

bind dram_refresh_sched dref_sched_chk #(.PAUSE_CYC(PAUSE_CYC)) u_chk (
  .clk(clk), .rst(rst), .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n),
  .mem_ready(mem_ready), .ovf_err(ovf_err)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
  localparam int PAUSE = 30, INTV = 20, WAKE = 8, MAXP = 3;
  localparam int CSR = 1, CHR = 1, RAS = 3, RP = 2;
  localparam int TOT = CSR + RAS + RP;

  logic clk = 1'b0, rst = 1'b1, ref_gnt = 1'b0, bus_own = 1'b0;
  logic ref_req, ras_n, mem_ready, ovf_err;
  logic [1:0] cas_n;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .REF_INTERVAL(INTV), .WAKE_CNT(WAKE), .MAX_PEND(MAXP),
    .T_CSR(CSR), .T_CHR(CHR), .T_RAS(RAS), .T_RP(RP)
  ) i_dram_refresh_sched (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .bus_own(bus_own),
    .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n),
    .mem_ready(mem_ready), .ovf_err(ovf_err)
  );

  // behavioural reference: phase 0 pause, 1 wake-up, 2 running
  int m_phase, m_timer, m_pend, m_busy, m_step, m_err, m_err_old, m_coinc;
  int t_req, t_done, t_start, t_tick;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_timer = 0; m_pend = 0; m_busy = 0; m_step = 0;
      m_err = 0; m_err_old = 0; m_coinc = 0;
    end else begin
      t_req   = (m_phase != 0 && m_pend != 0 && m_busy == 0) ? 1 : 0;
      t_done  = (m_busy == 1 && m_step == TOT - 1) ? 1 : 0;
      t_start = (t_req == 1 && (ref_gnt || bus_own)) ? 1 : 0;
      m_err_old = m_err;
      m_coinc = 0;
      if (m_phase == 0) begin
        if (m_timer == PAUSE - 1) begin m_phase = 1; m_pend = WAKE; m_timer = 0; end
        else m_timer++;
      end else if (m_phase == 1) begin
        if (t_done == 1) begin
          if (m_pend == 1) begin m_phase = 2; m_timer = 0; end
          m_pend--;
        end
      end else begin
        t_tick = (m_timer == INTV - 1) ? 1 : 0;
        m_timer = (t_tick == 1) ? 0 : m_timer + 1;
        if (t_tick == 1 && t_done == 0 && m_pend == MAXP) begin
          m_err = 1; m_phase = 1; m_pend = WAKE;
        end else begin
          m_pend = m_pend + t_tick - t_done;
          if (t_tick == 1 && t_done == 1) m_coinc = 1;
        end
      end
      if (t_done == 1) begin m_busy = 0; m_step = 0; end
      else if (m_busy == 1) m_step++;
      else if (t_start == 1) begin m_busy = 1; m_step = 0; end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input bit first);
    logic e_req, e_cas, e_ras;
    bit pre;
    e_req = (m_phase != 0 && m_pend != 0 && m_busy == 0);
    e_cas = !(m_busy == 1 && m_step < CSR + CHR);
    e_ras = !(m_busy == 1 && m_step >= CSR && m_step < CSR + RAS);
    pre   = (m_busy == 1 && m_step >= CSR + RAS);
    if (first) begin
      chk(ref_req, 1'b0, "R1", "ref_req");
      chk(mem_ready, 1'b0, "R1", "mem_ready");
      chk(ovf_err, 1'b0, "R1", "ovf_err");
      chk(ras_n, 1'b1, "R1", "ras_n");
      chk(cas_n[0] & cas_n[1], 1'b1, "R1", "cas_n");
    end
    chk(ref_req, e_req,
        m_phase == 0 ? "R2" : (m_coinc == 1 ? "R9" : (m_busy == 1 ? "R5" : (m_phase == 2 ? "R4" : "R3"))),
        "ref_req");
    chk(mem_ready, (m_phase == 2), m_phase == 0 ? "R2" : "R3", "mem_ready");
    chk(cas_n[0], e_cas, pre ? "R8" : "R6", "cas_n[0]");
    chk(cas_n[1], e_cas, pre ? "R8" : "R6", "cas_n[1]");
    chk(ras_n, e_ras, pre ? "R8" : "R7", "ras_n");
    chk(ovf_err, (m_err == 1), m_err_old == 1 ? "R11" : (m_coinc == 1 ? "R9" : "R10"), "ovf_err");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare(1'b0);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(1'b1);
    rst = 1'b0;
    run(1);
    compare(1'b1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // continuous grant: pause, wake-up burst, periodic refresh
    ref_gnt = 1'b1; bus_own = 1'b0;
    do_reset();
    run(400);
    // grant withheld: backlog overflows, then self-owned bus recovers
    ref_gnt = 1'b0;
    run(120);
    bus_own = 1'b1;
    run(200);
    bus_own = 1'b0; ref_gnt = 1'b1;
    run(60);
    // sweep grant release across the interval phase to hit tick and completion together
    for (int d = 0; d < 30; d++) begin
      ref_gnt = 1'b1;
      do_reset();
      run(90 + (d % 7));
      ref_gnt = 1'b0;
      run(d + 40);
      ref_gnt = 1'b1;
      run(60);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule